// File: doc/BRIEF.md
# PWM Output Break and Enable Controller

This block is the protection stage between a PWM timer's dead-time generator and the output pins. It keeps one main output-enable bit that gates all complementary output pairs. An external fault pin can clear that bit. The fault pin passes through a two-flop synchronizer, a selectable polarity and an enable bit before it counts as a break. A break also sets a sticky status flag, and that flag can raise an interrupt request.

After a fault the main enable comes back in one of two ways, chosen by a mode bit. It can come back by itself on the next timer update pulse, or only when software writes it again. The break acts on level: while the qualified break is present, software cannot set the main enable, the update pulse cannot set it, and software cannot clear the status flag. The main enable is resynchronized over two clock cycles before it reaches the pin stage. Each leg of a pair is then driven in one of three ways: running, idle (inactive level, or released), or disabled (programmed idle level).

A protection-level field can be written once after reset. It freezes a chosen set of settings so that a software fault cannot weaken the protection later. Registers are written through a synchronous write strobe. The read data is a combinational function of the address.

Top module: `brk_oe_ctrl`

## Requirements
- R1: After reset every register reads 0, irq is 0, moe_out is 0, and all pins and pin enables are 0. Register addresses: 0 control, 1 status, 2 protection, 3 output config, 4 output mode, 5 channel enable.
- R2: A qualified break clears control bit 0 (main enable) and sets status bit 0 (break flag) three clocks after the pin changes. irq is high when both the flag and control bit 2 (interrupt enable) are 1.
- R3: A break is qualified only when protection bit 8 (break enable) is 1 and the synchronized pin equals protection bit 9 (1 = active high, 0 = active low).
- R4: When control bit 1 (auto re-enable) is 1, a one-cycle uev pulse sets the main enable if no break is present. A uev pulse during a break has no effect.
- R5: When control bit 1 is 0, uev never sets the main enable, and a software write of 1 to control bit 0 does.
- R6: While a break is present, a write of 1 to the main enable and a write of 0 to the break flag both have no effect.
- R7: Writing 0 to status bit 0 clears the flag when no break is present. Writing 1 to it leaves the flag unchanged.
- R8: With the resynchronized main enable at 1, each leg's pin equals (dtg AND its channel enable) XOR its polarity bit, and its pin enable equals its channel enable. In output config, bit 2p is the main-leg polarity and bit 2p+1 the complementary-leg polarity. In the channel enable register, bit 2p enables the main leg and bit 2p+1 the complementary leg.
- R9: With the main enable at 0 and auto re-enable at 1 (idle), each leg's pin equals its polarity bit. Both pin enables of a pair are control bit 3 (off-state select) AND (either channel enable of that pair).
- R10: With both the main enable and auto re-enable at 0 (disabled), each leg's pin equals its idle bit, at output config bit 4+2p for the main leg and 5+2p for the complementary leg. Both pin enables of a pair are (either channel enable of that pair).
- R11: moe_out and the pin stage follow the main enable register two clocks late.
- R12: The protection level, protection bits 11:10, is taken from the first write to the protection register after reset. Later writes do not change it.
- R13: At level 1 or higher, the dead-time byte (protection bits 7:0), the break enable and the break polarity are frozen. At level 2 or higher the output config is also frozen. At level 3 the output mode is also frozen. The channel enables are never frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_pin | input | 1 | Raw fault input, asynchronous |
| uev | input | 1 | Timer update-event pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data |
| irq | output | 1 | Break interrupt request |
| moe_out | output | 1 | Resynchronized main enable to the dead-time stage |
| dt_cfg | output | 8 | Dead-time setting |
| mode_cfg | output | 4 | Output mode, 2 bits per pair |
| dtg_main | input | 2 | Main-leg reference per pair |
| dtg_comp | input | 2 | Complementary-leg reference per pair |
| pin_main | output | 2 | Main-leg pin level |
| pin_comp | output | 2 | Complementary-leg pin level |
| oe_main | output | 2 | Main-leg pin enable |
| oe_comp | output | 2 | Complementary-leg pin enable |

## Verification
The properties assume that uev is a pulse synchronous to clk and that a write does not arrive in the same cycle as a uev pulse. They also assume that reset is held for at least two clocks, so the resynchronizer is flushed. The bench drives every input on the falling edge and keeps the fault pin at each level for at least three clocks. During the randomized output-stage phase it holds the break disabled and the protection level at 0, so random register values only reach fields that are meant to take them.

// File: rtl/brk_oe_pkg.sv
// Shared definitions for the break and output-enable controller.
// Assumes a fixed 3-bit register address space.
package brk_oe_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_STAT   = 3'd1,
        REG_PROT   = 3'd2,
        REG_OUTCFG = 3'd3,
        REG_MODE   = 3'd4,
        REG_CHEN   = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_L1   = 2'd1,
        LK_L2   = 2'd2,
        LK_L3   = 2'd3
    } lock_lvl_e;

    typedef enum logic [1:0] {
        OST_RUN  = 2'd0,
        OST_IDLE = 2'd1,
        OST_OFF  = 2'd2
    } out_state_e;
endpackage

// File: rtl/brk_sync.sv
// Multi-stage flop synchronizer with a synchronous active-low reset to 0.
// Assumes STAGES >= 2. Adds STAGES cycles of latency.
module brk_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/brk_oe_regs.sv
// Register file: main enable, break flag, write-once protection level and
// protected configuration. Assumes brk_act is already synchronized and
// qualified. Read data is combinational on addr.
module brk_oe_regs
    import brk_oe_pkg::*;
#(
    parameter int NP     = 2,
    parameter int DATA_W = 16,
    parameter int DT_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  brk_act,
    input  logic                  uev,
    output logic                  moe_q,
    output logic                  aoe_q,
    output logic                  ie_q,
    output logic                  ossi_q,
    output logic                  flag_q,
    output logic [1:0]            lock_q,
    output logic                  lock_set_q,
    output logic [DT_W-1:0]       dt_q,
    output logic                  brk_en_q,
    output logic                  brk_pol_q,
    output logic [2*NP-1:0]       pol_q,
    output logic [2*NP-1:0]       idl_q,
    output logic [2*NP-1:0]       mode_q,
    output logic [2*NP-1:0]       chen_q
);
    localparam int LEG_N     = 2 * NP;
    localparam int PR_EN_B   = DT_W;
    localparam int PR_POL_B  = DT_W + 1;
    localparam int PR_LK_LO  = DT_W + 2;
    localparam int PR_TOP    = DT_W + 4;

    logic wr_ctrl, wr_stat, wr_prot, wr_ocfg, wr_mode, wr_chen;
    logic unused_wdata;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_stat = wr_en && (addr == REG_STAT);
    assign wr_prot = wr_en && (addr == REG_PROT);
    assign wr_ocfg = wr_en && (addr == REG_OUTCFG);
    assign wr_mode = wr_en && (addr == REG_MODE);
    assign wr_chen = wr_en && (addr == REG_CHEN);
    assign unused_wdata = ^wdata[DATA_W-1:PR_TOP];

    // main enable: break wins, then software, then auto re-enable on update
    always_ff @(posedge clk) begin
        if (!rst_n)            moe_q <= 1'b0;
        else if (brk_act)      moe_q <= 1'b0;
        else if (wr_ctrl)      moe_q <= wdata[0];
        else if (aoe_q && uev) moe_q <= 1'b1;
    end

    // plain control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aoe_q  <= 1'b0;
            ie_q   <= 1'b0;
            ossi_q <= 1'b0;
        end else if (wr_ctrl) begin
            aoe_q  <= wdata[1];
            ie_q   <= wdata[2];
            ossi_q <= wdata[3];
        end
    end

    // sticky break flag, cleared by writing 0 only when no break is present
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (brk_act)                flag_q <= 1'b1;
        else if (wr_stat && !wdata[0])   flag_q <= 1'b0;
    end

    // protection level taken from the first protection write only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q     <= LK_NONE;
            lock_set_q <= 1'b0;
        end else if (wr_prot && !lock_set_q) begin
            lock_q     <= wdata[PR_LK_LO +: 2];
            lock_set_q <= 1'b1;
        end
    end

    // dead-time and break qualification, frozen from level 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q      <= '0;
            brk_en_q  <= 1'b0;
            brk_pol_q <= 1'b0;
        end else if (wr_prot && (lock_q == LK_NONE)) begin
            dt_q      <= wdata[DT_W-1:0];
            brk_en_q  <= wdata[PR_EN_B];
            brk_pol_q <= wdata[PR_POL_B];
        end
    end

    // polarity and idle levels, frozen from level 2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            idl_q <= '0;
        end else if (wr_ocfg && (lock_q < LK_L2)) begin
            pol_q <= wdata[LEG_N-1:0];
            idl_q <= wdata[LEG_N +: LEG_N];
        end
    end

    // output mode, frozen at level 3
    always_ff @(posedge clk) begin
        if (!rst_n)                             mode_q <= '0;
        else if (wr_mode && (lock_q < LK_L3))   mode_q <= wdata[LEG_N-1:0];
    end

    // channel enables, never frozen
    always_ff @(posedge clk) begin
        if (!rst_n)       chen_q <= '0;
        else if (wr_chen) chen_q <= wdata[LEG_N-1:0];
    end

    // read-back multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL:   rdata[3:0] = {ossi_q, ie_q, aoe_q, moe_q};
            REG_STAT:   rdata[0] = flag_q;
            REG_PROT: begin
                rdata[DT_W-1:0]      = dt_q;
                rdata[PR_EN_B]       = brk_en_q;
                rdata[PR_POL_B]      = brk_pol_q;
                rdata[PR_LK_LO +: 2] = lock_q;
            end
            REG_OUTCFG: begin
                rdata[LEG_N-1:0]     = pol_q;
                rdata[LEG_N +: LEG_N] = idl_q;
            end
            REG_MODE:   rdata[LEG_N-1:0] = mode_q;
            REG_CHEN:   rdata[LEG_N-1:0] = chen_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/brk_oe_outstage.sv
// Pin stage: drives each complementary pair as running, idle or disabled,
// from the resynchronized main enable. Assumes moe_s is already resynchronized.
module brk_oe_outstage
    import brk_oe_pkg::*;
#(
    parameter int NP = 2
) (
    input  logic            moe_s,
    input  logic            aoe,
    input  logic            ossi,
    input  logic [2*NP-1:0] pol,
    input  logic [2*NP-1:0] idl,
    input  logic [2*NP-1:0] chen,
    input  logic [NP-1:0]   dtg_main,
    input  logic [NP-1:0]   dtg_comp,
    output logic [NP-1:0]   pin_main,
    output logic [NP-1:0]   pin_comp,
    output logic [NP-1:0]   oe_main,
    output logic [NP-1:0]   oe_comp
);
    out_state_e st;

    // pick the shared output state
    always_comb begin
        if (moe_s)    st = OST_RUN;
        else if (aoe) st = OST_IDLE;
        else          st = OST_OFF;
    end

    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam int M = 2 * p;
        localparam int C = 2 * p + 1;
        logic any_en;
        assign any_en = chen[M] | chen[C];

        // drive one pair according to the state
        always_comb begin
            case (st)
                OST_RUN: begin
                    pin_main[p] = (dtg_main[p] & chen[M]) ^ pol[M];
                    pin_comp[p] = (dtg_comp[p] & chen[C]) ^ pol[C];
                    oe_main[p]  = chen[M];
                    oe_comp[p]  = chen[C];
                end
                OST_IDLE: begin
                    pin_main[p] = pol[M];
                    pin_comp[p] = pol[C];
                    oe_main[p]  = ossi & any_en;
                    oe_comp[p]  = ossi & any_en;
                end
                default: begin
                    pin_main[p] = idl[M];
                    pin_comp[p] = idl[C];
                    oe_main[p]  = any_en;
                    oe_comp[p]  = any_en;
                end
            endcase
        end
    end
endmodule

// File: rtl/brk_oe_ctrl.sv
// Top of the break and output-enable controller. Synchronizes and qualifies
// the fault pin, holds the registers, resynchronizes the main enable and
// drives the pin stage. Assumes brk_pin is asynchronous and uev is synchronous.
module brk_oe_ctrl
    import brk_oe_pkg::*;
#(
    parameter int NP       = 2,
    parameter int DATA_W   = 16,
    parameter int DT_W     = 8,
    parameter int SYNC_STG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  brk_pin,
    input  logic                  uev,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq,
    output logic                  moe_out,
    output logic [DT_W-1:0]       dt_cfg,
    output logic [2*NP-1:0]       mode_cfg,
    input  logic [NP-1:0]         dtg_main,
    input  logic [NP-1:0]         dtg_comp,
    output logic [NP-1:0]         pin_main,
    output logic [NP-1:0]         pin_comp,
    output logic [NP-1:0]         oe_main,
    output logic [NP-1:0]         oe_comp
);
    logic brk_s, brk_act;
    logic moe_q, aoe_q, ie_q, ossi_q, flag_q, lock_set_q;
    logic brk_en_q, brk_pol_q;
    logic [1:0] lock_q;
    logic [2*NP-1:0] pol_q, idl_q, chen_q;

    brk_sync #(.WIDTH(1), .STAGES(SYNC_STG)) brk_sync_i (
        .clk(clk), .rst_n(rst_n), .d(brk_pin), .q(brk_s)
    );

    assign brk_act = brk_en_q && (brk_s == brk_pol_q);

    brk_oe_regs #(.NP(NP), .DATA_W(DATA_W), .DT_W(DT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .brk_act(brk_act), .uev(uev),
        .moe_q(moe_q), .aoe_q(aoe_q), .ie_q(ie_q), .ossi_q(ossi_q),
        .flag_q(flag_q), .lock_q(lock_q), .lock_set_q(lock_set_q),
        .dt_q(dt_cfg), .brk_en_q(brk_en_q), .brk_pol_q(brk_pol_q),
        .pol_q(pol_q), .idl_q(idl_q), .mode_q(mode_cfg), .chen_q(chen_q)
    );

    brk_sync #(.WIDTH(1), .STAGES(SYNC_STG)) moe_sync_i (
        .clk(clk), .rst_n(rst_n), .d(moe_q), .q(moe_out)
    );

    assign irq = flag_q & ie_q;

    brk_oe_outstage #(.NP(NP)) out_i (
        .moe_s(moe_out), .aoe(aoe_q), .ossi(ossi_q),
        .pol(pol_q), .idl(idl_q), .chen(chen_q),
        .dtg_main(dtg_main), .dtg_comp(dtg_comp),
        .pin_main(pin_main), .pin_comp(pin_comp),
        .oe_main(oe_main), .oe_comp(oe_comp)
    );
endmodule

// File: rtl/brk_oe_chk.sv
// Property checker for brk_oe_ctrl, attached with bind.
// Assumes uev does not coincide with a control write.
module brk_oe_chk
    import brk_oe_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  brk_act,
    input logic                  moe_q,
    input logic                  moe_out,
    input logic                  flag_q,
    input logic                  ie_q,
    input logic                  aoe_q,
    input logic                  irq,
    input logic                  uev,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] addr,
    input logic                  wdata0,
    input logic [1:0]            lock_q,
    input logic                  lock_set_q
);
    logic [1:0] cyc;
    logic wr_ctrl;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);

    // count cycles since reset for the latency property
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R2
    brk_clears_moe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> !moe_q);
    // R2
    brk_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> flag_q);
    // R2
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);
    // R4
    auto_reen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aoe_q && uev && !brk_act && !wr_ctrl) |=> moe_q);
    // R5
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aoe_q && !moe_q && !wr_ctrl) |=> !moe_q);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && addr == REG_STAT && !wdata0)) |=> flag_q);
    // R11
    moe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (moe_out == $past(moe_q, 2)));
    // R12
    lock_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set_q |=> $stable(lock_q));
endmodule

bind brk_oe_ctrl brk_oe_chk chk_i (
    .clk(clk), .rst_n(rst_n), .brk_act(brk_act), .moe_q(moe_q),
    .moe_out(moe_out), .flag_q(flag_q), .ie_q(ie_q), .aoe_q(aoe_q),
    .irq(irq), .uev(uev), .wr_en(wr_en), .addr(addr), .wdata0(wdata[0]),
    .lock_q(lock_q), .lock_set_q(lock_set_q)
);

// File: tb/brk_oe_ctrl_tb_top.sv
module brk_oe_ctrl_tb_top;
    localparam int A_CTRL = 0, A_STAT = 1, A_PROT = 2, A_OCFG = 3, A_MODE = 4, A_CHEN = 5;

    logic clk = 1'b0;
    logic rst_n, brk_pin, uev, wr_en, irq, moe_out;
    logic [2:0] addr;
    logic [15:0] wdata, rdata;
    logic [7:0] dt_cfg;
    logic [3:0] mode_cfg;
    logic [1:0] dtg_main, dtg_comp, pin_main, pin_comp, oe_main, oe_comp;
    int n_tests = 0;
    int n_fail = 0;
    logic [15:0] v;

    always #5 clk = ~clk;

    brk_oe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .brk_pin(brk_pin), .uev(uev), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .moe_out(moe_out),
        .dt_cfg(dt_cfg), .mode_cfg(mode_cfg), .dtg_main(dtg_main), .dtg_comp(dtg_comp),
        .pin_main(pin_main), .pin_comp(pin_comp), .oe_main(oe_main), .oe_comp(oe_comp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; brk_pin = 1'b0; uev = 1'b0;
        addr = '0; wdata = '0; dtg_main = '0; dtg_comp = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        addr = 3'(a);
        #1 d = rdata;
    endtask

    task automatic pulse_uev();
        @(negedge clk);
        uev = 1'b1;
        @(negedge clk);
        uev = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected {oe_comp, oe_main, pin_comp, pin_main} from the output-state rules
    function automatic logic [7:0] exp_pins(input logic moe, input logic aoe, input logic ossi,
                                           input logic [3:0] pol, input logic [3:0] idl,
                                           input logic [3:0] en, input logic [1:0] dm,
                                           input logic [1:0] dc);
        logic [7:0] r;
        r = '0;
        for (int p = 0; p < 2; p++) begin
            logic either;
            either = en[2*p] || en[2*p+1];
            if (moe) begin
                r[p]   = pol[2*p]   ^ (dm[p] && en[2*p]);
                r[2+p] = pol[2*p+1] ^ (dc[p] && en[2*p+1]);
                r[4+p] = en[2*p];
                r[6+p] = en[2*p+1];
            end else if (aoe) begin
                r[p]   = pol[2*p];
                r[2+p] = pol[2*p+1];
                r[4+p] = ossi && either;
                r[6+p] = ossi && either;
            end else begin
                r[p]   = idl[2*p];
                r[2+p] = idl[2*p+1];
                r[4+p] = either;
                r[6+p] = either;
            end
        end
        return r;
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed);

        // R1: reset values
        do_reset();
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            chk("R1 register", {16'(a), v}, {16'(a), 16'h0});
        end
        chk("R1 outputs", {irq, moe_out, pin_main, pin_comp, oe_main, oe_comp}, '0);

        // R11: moe_out lags the control write by two clocks
        wr(A_CTRL, 16'h0001);
        chk("R11 lag0", moe_out, 1'b0);
        wait_n(1);
        chk("R11 lag1", moe_out, 1'b0);
        wait_n(1);
        chk("R11 lag2", moe_out, 1'b1);

        // R2, R5, R6, R7: break entry, manual recovery
        do_reset();
        wr(A_PROT, 16'h0300);
        wr(A_CTRL, 16'h0005);
        @(negedge clk) brk_pin = 1'b1;
        wait_n(3);
        rd(A_CTRL, v); chk("R2 moe cleared", v[0], 1'b0);
        rd(A_STAT, v); chk("R2 flag set", v[0], 1'b1);
        chk("R2 irq", irq, 1'b1);
        wr(A_CTRL, 16'h0005);
        rd(A_CTRL, v); chk("R6 moe write blocked", v[0], 1'b0);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); chk("R6 flag clear blocked", v[0], 1'b1);
        @(negedge clk) brk_pin = 1'b0;
        wait_n(3);
        pulse_uev();
        rd(A_CTRL, v); chk("R5 uev ignored", v[0], 1'b0);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v); chk("R7 write 1 keeps flag", v[0], 1'b1);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); chk("R7 flag cleared", v[0], 1'b0);
        chk("R2 irq low", irq, 1'b0);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v); chk("R7 write 1 no set", v[0], 1'b0);
        wr(A_CTRL, 16'h0005);
        rd(A_CTRL, v); chk("R5 software set", v[0], 1'b1);

        // R4: automatic re-enable on update after break ends
        wr(A_CTRL, 16'h0003);
        @(negedge clk) brk_pin = 1'b1;
        wait_n(3);
        rd(A_CTRL, v); chk("R4 break clears", v[0], 1'b0);
        chk("R2 irq masked", irq, 1'b0);
        pulse_uev();
        rd(A_CTRL, v); chk("R4 uev during break", v[0], 1'b0);
        @(negedge clk) brk_pin = 1'b0;
        wait_n(3);
        rd(A_CTRL, v); chk("R4 no uev yet", v[0], 1'b0);
        pulse_uev();
        rd(A_CTRL, v); chk("R4 uev re-enables", v[0], 1'b1);

        // R3: enable and polarity qualification
        do_reset();
        wr(A_PROT, 16'h0200);
        wr(A_CTRL, 16'h0001);
        @(negedge clk) brk_pin = 1'b1;
        wait_n(3);
        rd(A_CTRL, v); chk("R3 disabled break", v[0], 1'b1);
        rd(A_STAT, v); chk("R3 disabled flag", v[0], 1'b0);
        do_reset();
        @(negedge clk) brk_pin = 1'b1;
        wait_n(3);
        wr(A_PROT, 16'h0100);
        wr(A_CTRL, 16'h0001);
        wait_n(3);
        rd(A_CTRL, v); chk("R3 active-low idle", v[0], 1'b1);
        @(negedge clk) brk_pin = 1'b0;
        wait_n(3);
        rd(A_CTRL, v); chk("R3 active-low trips", v[0], 1'b0);

        // R12: first write fixes level 0
        do_reset();
        wr(A_PROT, 16'h0012);
        wr(A_PROT, 16'h0C34);
        rd(A_PROT, v); chk("R12 level stays 0", v, 16'h0034);
        // R13 level 1
        do_reset();
        wr(A_PROT, 16'h0412);
        wr(A_PROT, 16'h0B34);
        rd(A_PROT, v); chk("R13 level1 prot frozen", v, 16'h0412);
        chk("R13 dt port", dt_cfg, 8'h12);
        wr(A_OCFG, 16'h005A);
        rd(A_OCFG, v); chk("R13 level1 ocfg open", v, 16'h005A);
        wr(A_MODE, 16'h0009);
        rd(A_MODE, v); chk("R13 level1 mode open", v, 16'h0009);
        // R13 level 2
        do_reset();
        wr(A_PROT, 16'h0800);
        wr(A_OCFG, 16'h005A);
        rd(A_OCFG, v); chk("R13 level2 ocfg frozen", v, 16'h0000);
        wr(A_MODE, 16'h0006);
        rd(A_MODE, v); chk("R13 level2 mode open", v, 16'h0006);
        // R13 level 3
        do_reset();
        wr(A_PROT, 16'h0C00);
        wr(A_MODE, 16'h0006);
        rd(A_MODE, v); chk("R13 level3 mode frozen", v, 16'h0000);
        chk("R13 mode port", mode_cfg, 4'h0);
        wr(A_CHEN, 16'h000F);
        rd(A_CHEN, v); chk("R13 chen open", v, 16'h000F);

        // R8, R9, R10: random output-stage configurations
        do_reset();
        for (int it = 0; it < 60; it++) begin
            logic [3:0] pol, idl, en;
            logic moe, aoe, ossi;
            logic [7:0] got;
            pol = 4'($urandom); idl = 4'($urandom); en = 4'($urandom);
            moe = 1'($urandom); aoe = 1'($urandom); ossi = 1'($urandom);
            wr(A_OCFG, {8'h0, idl, pol});
            wr(A_CHEN, {12'h0, en});
            wr(A_CTRL, {12'h0, ossi, 1'b0, aoe, moe});
            @(negedge clk);
            dtg_main = 2'($urandom); dtg_comp = 2'($urandom);
            wait_n(2);
            got = {oe_comp, oe_main, pin_comp, pin_main};
            chk(moe ? "R8 run" : (aoe ? "R9 idle" : "R10 disabled"), got,
                exp_pins(moe, aoe, ossi, pol, idl, en, dtg_main, dtg_comp));
        end

        summary();
    end
endmodule